// File: doc/BRIEF.md
# EPP Cycle Controller

This block sits behind a small CPU register window and turns accesses at two
of its offsets into enhanced parallel port transfers on an 8-bit bidirectional
peripheral port. An access at offset 3 runs an address transfer and an access
at offset 4 runs a data transfer. Each transfer byte is a strobe/wait
handshake. The strobe is driven low. The peripheral raises `pp_wait` to
accept or supply the byte. The strobe is then released, and the peripheral
drops `pp_wait` again. A transfer starts only when the control register holds
the exact pattern required for that direction. Otherwise the access completes
with no activity on the port.

The register side is a single-outstanding valid/ready request channel with a
one-cycle response pulse. A request is taken on a clock edge where `req_valid`
and `req_ready` are both high. `req_ready` then stays low until the response
has been given, which applies back-pressure for as long as the port transfer
lasts. `rsp_valid` is high for exactly one cycle and cannot be stalled.
`rsp_rdata` is meaningful only for reads and is zero for writes. Data-offset
accesses of two or four bytes run as back-to-back byte transfers. A peripheral
that fails to answer within `WAIT_LIMIT` clocks aborts the access and sets a
sticky timeout flag.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: A launched access at offset 3 pulses only `pp_astb_n` and one at offset 4 pulses only `pp_dstb_n`. The two strobes are never low together.
- R2: A write at offset 3 or 4 runs only when control AND 0x2F equals 0x04. This requires direction (0x20), select (0x08), auto-feed (0x02) and strobe (0x01) all clear, with init (0x04) set. Otherwise no strobe toggles and no byte leaves the port.
- R3: A read at offset 3 or 4 runs only when control AND 0x2F equals 0x24. Otherwise no strobe toggles and the response is all ones in the accessed width, zero above it.
- R4: A handshake phase that does not complete within `WAIT_LIMIT` clocks ends the access, releases the strobe and sets the timeout flag. The flag reads as bit 0 of status (offset 1), and status bits 7..1 read zero.
- R5: The timeout flag stays set across reads and stays set across status writes that have bit 0 clear. A status write with bit 0 set clears it.
- R6: Control (offset 2) resets to 0xCC. Every write stores the value OR 0xC0, so reads always return bits 7 and 6 set.
- R7: At offset 4, `req_size` 0 moves 1 byte, 1 moves 2 bytes, and 2 or 3 move 4 bytes. Bytes go least significant first, and read bytes land in the same order. Offset 3 always moves 1 byte.
- R8: A timeout skips the remaining bytes of a wide access. Read bytes not transferred return as 0xFF inside the accessed width.
- R9: `req_ready` is low from acceptance until the response, and low whenever a strobe is asserted. `rsp_valid` is a one-cycle pulse following every accepted request.
- R10: `pp_doe` is high only during write transfers. `pp_write_n` is low for the whole of a write transfer and high during reads.
- R11: A strobe is asserted only while `pp_wait` is low. Each byte is handed over exactly once per handshake.
- R12: Offset 0 is a plain byte register that resets to 0x00 and reads back what was written. Offsets 5 to 7 read 0xFF and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 3 | Register offset in the window |
| req_size | input | 2 | Access width code (0:1, 1:2, 2/3:4 bytes) |
| req_wdata | input | DW | Write data, least significant byte first |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DW | Read data for the response |
| pp_write_n | output | 1 | Low during write transfers |
| pp_astb_n | output | 1 | Address strobe, active low |
| pp_dstb_n | output | 1 | Data strobe, active low |
| pp_wait | input | 1 | Peripheral handshake |
| pp_din | input | 8 | Byte from the peripheral |
| pp_dout | output | 8 | Byte to the peripheral |
| pp_doe | output | 1 | Output enable for `pp_dout` |

## Verification
A corrupted control register shows up on the very next port access. The wrong
gate decision either toggles a strobe that must stay idle or leaves one idle,
and a control read exposes the stored value one cycle after acceptance. A byte
index or byte-count fault appears as bytes in the wrong order, or as too many
or too few bytes at the peripheral, within the same access. A lost or stuck
timeout flag is visible on the first status read after the failing transfer,
and a timer fault shows as a strobe held past `WAIT_LIMIT` clocks.

// File: rtl/epp_pkg.sv
package epp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STRB = 2'd1,
    ST_REL  = 2'd2,
    ST_RESP = 2'd3
  } seq_state_e;

  localparam logic [2:0] OFF_PLAIN = 3'd0;
  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_CTRL  = 3'd2;
  localparam logic [2:0] OFF_XADDR = 3'd3;
  localparam logic [2:0] OFF_XDATA = 3'd4;

  localparam logic [7:0] CTL_DIR    = 8'h20;
  localparam logic [7:0] CTL_INIT   = 8'h04;
  localparam logic [7:0] CTL_GATE   = 8'h2F;
  localparam logic [7:0] CTL_FORCED = 8'hC0;
  localparam logic [7:0] CTL_RESET  = 8'hCC;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/epp_regs.sv
module epp_regs
  import epp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       acc_write,
  input  logic [2:0] acc_off,
  input  logic [7:0] acc_wbyte,
  input  logic       tmo_set,
  output logic       wr_gate_ok,
  output logic       rd_gate_ok,
  output logic [7:0] reg_rbyte
);

  logic [7:0] ctl_q;
  logic [7:0] plain_q;
  logic       tmo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= CTL_RESET;
      plain_q <= 8'h00;
      tmo_q   <= 1'b0;
    end else begin
      if (tmo_set) tmo_q <= 1'b1;
      if (acc && acc_write) begin
        case (acc_off)
          OFF_PLAIN: plain_q <= acc_wbyte;
          OFF_STAT:  if (acc_wbyte[0]) tmo_q <= 1'b0;
          OFF_CTRL:  ctl_q <= acc_wbyte | CTL_FORCED;
          default:   ;
        endcase
      end
    end
  end

  assign wr_gate_ok = (ctl_q & CTL_GATE) == CTL_INIT;
  assign rd_gate_ok = (ctl_q & CTL_GATE) == (CTL_DIR | CTL_INIT);

  always_comb begin
    case (acc_off)
      OFF_PLAIN: reg_rbyte = plain_q;
      OFF_STAT:  reg_rbyte = {7'd0, tmo_q};
      OFF_CTRL:  reg_rbyte = ctl_q;
      default:   reg_rbyte = 8'hFF;
    endcase
  end

endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);

  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (run)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/epp_seq.sv
module epp_seq
  import epp_pkg::*;
#(
  parameter int DW         = 32,
  parameter int WAIT_LIMIT = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          acc_write,
  input  logic [2:0]    acc_off,
  input  logic [1:0]    acc_size,
  input  logic [DW-1:0] acc_wdata,
  input  logic          wr_gate_ok,
  input  logic          rd_gate_ok,
  input  logic [7:0]    reg_rbyte,
  input  logic          pp_wait,
  input  logic [7:0]    pp_din,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          pp_write_n,
  output logic          pp_astb_n,
  output logic          pp_dstb_n,
  output logic [7:0]    pp_dout,
  output logic          pp_doe,
  output logic          tmo_set
);

  localparam int NB = DW / 8;
  localparam int IW = (NB < 2) ? 1 : $clog2(NB);

  seq_state_e    state_q, state_n;
  logic          is_wr_q, is_addr_q;
  logic [IW-1:0] idx_q, last_q;
  logic [DW-1:0] wbuf_q, rbuf_q, rmask_q, rsp_q;

  logic          is_xfer, launch, expired, tmo_fire, in_cycle;
  logic [2:0]    nb_raw, nb;
  logic [DW-1:0] mask_n;

  function automatic logic [DW-1:0] width_mask(input logic [2:0] n);
    logic [DW-1:0] m;
    for (int b = 0; b < NB; b++) m[b*8 +: 8] = (b < int'(n)) ? 8'hFF : 8'h00;
    return m;
  endfunction

  assign is_xfer = (acc_off == OFF_XADDR) || (acc_off == OFF_XDATA);
  assign launch  = is_xfer && (acc_write ? wr_gate_ok : rd_gate_ok);
  assign nb_raw  = (acc_off == OFF_XDATA) ? size_to_bytes(acc_size) : 3'd1;
  assign nb      = (int'(nb_raw) > NB) ? 3'(NB) : nb_raw;
  assign mask_n  = width_mask(nb);
  assign in_cycle = (state_q == ST_STRB) || (state_q == ST_REL);

  always_comb begin
    state_n  = state_q;
    tmo_fire = 1'b0;
    case (state_q)
      ST_IDLE: if (acc) state_n = launch ? ST_STRB : ST_RESP;
      ST_STRB: begin
        if (pp_wait) state_n = ST_REL;
        else if (expired) begin
          state_n  = ST_RESP;
          tmo_fire = 1'b1;
        end
      end
      ST_REL: begin
        if (!pp_wait) state_n = (idx_q == last_q) ? ST_RESP : ST_STRB;
        else if (expired) begin
          state_n  = ST_RESP;
          tmo_fire = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  epp_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state_n != state_q),
    .run     (in_cycle),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      is_wr_q   <= 1'b0;
      is_addr_q <= 1'b0;
      idx_q     <= '0;
      last_q    <= '0;
      wbuf_q    <= '0;
      rbuf_q    <= '1;
      rmask_q   <= '0;
      rsp_q     <= '0;
    end else begin
      state_q <= state_n;
      case (state_q)
        ST_IDLE: begin
          if (acc) begin
            is_wr_q   <= acc_write;
            is_addr_q <= (acc_off == OFF_XADDR);
            idx_q     <= '0;
            last_q    <= IW'(nb - 3'd1);
            wbuf_q    <= acc_wdata;
            rbuf_q    <= '1;
            rmask_q   <= mask_n;
            if (acc_write)    rsp_q <= '0;
            else if (is_xfer) rsp_q <= mask_n;
            else              rsp_q <= DW'(reg_rbyte);
          end
        end
        ST_STRB: begin
          if (pp_wait && !is_wr_q) begin
            for (int b = 0; b < NB; b++)
              if (IW'(b) == idx_q) rbuf_q[b*8 +: 8] <= pp_din;
          end
          if (state_n == ST_RESP) rsp_q <= is_wr_q ? '0 : (rbuf_q & rmask_q);
        end
        ST_REL: begin
          if (state_n == ST_STRB) idx_q <= idx_q + 1'b1;
          if (state_n == ST_RESP) rsp_q <= is_wr_q ? '0 : (rbuf_q & rmask_q);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    pp_dout = 8'h00;
    for (int b = 0; b < NB; b++)
      if (IW'(b) == idx_q) pp_dout = wbuf_q[b*8 +: 8];
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_rdata  = rsp_q;
  assign pp_write_n = !(in_cycle && is_wr_q);
  assign pp_doe     = in_cycle && is_wr_q;
  assign pp_astb_n  = !((state_q == ST_STRB) && is_addr_q);
  assign pp_dstb_n  = !((state_q == ST_STRB) && !is_addr_q);
  assign tmo_set    = tmo_fire;

endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_pkg::*;
#(
  parameter int DW         = 32,
  parameter int WAIT_LIMIT = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [2:0]    req_offset,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          pp_write_n,
  output logic          pp_astb_n,
  output logic          pp_dstb_n,
  input  logic          pp_wait,
  input  logic [7:0]    pp_din,
  output logic [7:0]    pp_dout,
  output logic          pp_doe
);

  logic       acc;
  logic       wr_gate_ok, rd_gate_ok, tmo_set;
  logic [7:0] reg_rbyte;

  assign acc = req_valid && req_ready;

  epp_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .acc_write  (req_write),
    .acc_off    (req_offset),
    .acc_wbyte  (req_wdata[7:0]),
    .tmo_set    (tmo_set),
    .wr_gate_ok (wr_gate_ok),
    .rd_gate_ok (rd_gate_ok),
    .reg_rbyte  (reg_rbyte)
  );

  epp_seq #(.DW(DW), .WAIT_LIMIT(WAIT_LIMIT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .acc_write  (req_write),
    .acc_off    (req_offset),
    .acc_size   (req_size),
    .acc_wdata  (req_wdata),
    .wr_gate_ok (wr_gate_ok),
    .rd_gate_ok (rd_gate_ok),
    .reg_rbyte  (reg_rbyte),
    .pp_wait    (pp_wait),
    .pp_din     (pp_din),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .pp_write_n (pp_write_n),
    .pp_astb_n  (pp_astb_n),
    .pp_dstb_n  (pp_dstb_n),
    .pp_dout    (pp_dout),
    .pp_doe     (pp_doe),
    .tmo_set    (tmo_set)
  );

endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk #(
  parameter int DW         = 32,
  parameter int WAIT_LIMIT = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [2:0]    req_offset,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic          pp_write_n,
  input logic          pp_astb_n,
  input logic          pp_dstb_n,
  input logic          pp_wait,
  input logic          pp_doe
);

  localparam int SW = $clog2(WAIT_LIMIT + 2) + 1;

  logic          any_stb;
  logic [SW-1:0] stb_run_q;
  logic          ctl_rd_pend_q;

  assign any_stb = !pp_astb_n || !pp_dstb_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_run_q     <= '0;
      ctl_rd_pend_q <= 1'b0;
    end else begin
      stb_run_q <= any_stb ? stb_run_q + 1'b1 : '0;
      if (req_valid && req_ready && !req_write && req_offset == 3'd2) ctl_rd_pend_q <= 1'b1;
      else if (rsp_valid) ctl_rd_pend_q <= 1'b0;
    end
  end

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pp_astb_n && !pp_dstb_n));

  assert_strobe_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_run_q <= SW'(WAIT_LIMIT));

  assert_ctl_fixed_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ctl_rd_pend_q) |-> (rsp_rdata[7:6] == 2'b11));

  assert_stall_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> !req_ready);

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_doe_in_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pp_doe |-> !pp_write_n);

  assert_strobe_after_wait_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_stb) |-> !pp_wait);

endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk #(.DW(DW), .WAIT_LIMIT(WAIT_LIMIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_offset (req_offset),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .pp_write_n (pp_write_n),
  .pp_astb_n  (pp_astb_n),
  .pp_dstb_n  (pp_dstb_n),
  .pp_wait    (pp_wait),
  .pp_doe     (pp_doe)
);

// File: tb/epp_cycle_ctrl_tb.sv
module epp_cycle_ctrl_tb;

  localparam int DW = 32;
  localparam int WL = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]    req_offset = '0;
  logic [1:0]    req_size = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          pp_write_n, pp_astb_n, pp_dstb_n, pp_doe;
  logic          pp_wait = 1'b0;
  logic [7:0]    pp_din = 8'h00, pp_dout;

  always #5 clk = ~clk;

  epp_cycle_ctrl #(.DW(DW), .WAIT_LIMIT(WL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pp_write_n(pp_write_n), .pp_astb_n(pp_astb_n), .pp_dstb_n(pp_dstb_n),
    .pp_wait(pp_wait), .pp_din(pp_din), .pp_dout(pp_dout), .pp_doe(pp_doe)
  );

  // peripheral model
  int         served = 0, rd_idx = 0, log_n = 0, serve_limit;
  int         dly_cnt = 0, dly_tgt = 0;
  logic [8:0] log_mem [0:1023];

  always @(posedge clk) begin
    if (!rst_n) begin
      pp_wait <= 1'b0;
      dly_cnt <= 0;
    end else if ((!pp_astb_n || !pp_dstb_n) && !pp_wait) begin
      if (served < serve_limit) begin
        if (dly_cnt >= dly_tgt) begin
          pp_wait <= 1'b1;
          dly_cnt <= 0;
          served  <= served + 1;
          dly_tgt <= int'($urandom_range(0, 3));
          if (!pp_write_n) begin
            if (log_n < 1024) log_mem[log_n] <= {!pp_astb_n, pp_dout};
            log_n <= log_n + 1;
          end else begin
            pp_din <= 8'(8'hA0 + rd_idx);
            rd_idx <= rd_idx + 1;
          end
        end else dly_cnt <= dly_cnt + 1;
      end
    end else if (pp_astb_n && pp_dstb_n && pp_wait) begin
      pp_wait <= 1'b0;
    end
  end

  // port monitor
  int   astb_cnt = 0, dstb_cnt = 0, mon_bad_r10 = 0, mon_bad_r1 = 0;
  logic astb_prev = 1'b1, dstb_prev = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!pp_astb_n && astb_prev) astb_cnt <= astb_cnt + 1;
      if (!pp_dstb_n && dstb_prev) dstb_cnt <= dstb_cnt + 1;
      if (pp_doe && pp_write_n) mon_bad_r10 <= mon_bad_r10 + 1;
      if ((!pp_astb_n || !pp_dstb_n) && !pp_write_n && !pp_doe) mon_bad_r10 <= mon_bad_r10 + 1;
      if (!pp_astb_n && !pp_dstb_n) mon_bad_r1 <= mon_bad_r1 + 1;
    end
    astb_prev <= pp_astb_n;
    dstb_prev <= pp_dstb_n;
  end

  int n_chk = 0, n_bad = 0;
  logic [7:0] ctl_sh;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [2:0] off, input logic [1:0] sz);
    if (off != 3'd4) return 1;
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] ones_w(input int nb);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) if (k < nb) r[k*8 +: 8] = 8'hFF;
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input int nb, input int got_nb, input int base);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (k < got_nb) r[k*8 +: 8] = 8'(8'hA0 + base + k);
      else if (k < nb) r[k*8 +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic access(input bit wr, input logic [2:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = off; req_size = sz; req_wdata = wd;
    guard = 0;
    while (!req_ready && guard < 2000) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 ready low after accept", {31'd0, req_ready}, 32'd0);
    guard = 0;
    while (!rsp_valid && guard < 2000) begin @(negedge clk); guard++; end
    chk("R9 response arrives", {31'd0, rsp_valid}, 32'd1);
    rd = rsp_rdata;
    @(negedge clk);
    chk("R9 response single cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic chk_log(input string req, input int start, input int nb,
                         input logic [31:0] wd, input bit is_addr);
    for (int k = 0; k < nb; k++)
      chk(req, {23'd0, log_mem[start + k]}, {23'd0, is_addr, wd[k*8 +: 8]});
  endtask

  task automatic set_ctl(input logic [7:0] v);
    logic [31:0] d;
    access(1'b1, 3'd2, 2'd0, {24'd0, v}, d);
    ctl_sh = v | 8'hC0;
  endtask

  task automatic run_all();
    logic [31:0] d;
    int l0, a0, d0, r0;
    serve_limit = 32'h3FFF_FFFF;
    ctl_sh = 8'hCC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R9 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R9 reset no rsp", {31'd0, rsp_valid}, 32'd0);
    chk("R10 reset port idle", {28'd0, pp_astb_n, pp_dstb_n, pp_write_n, pp_doe}, 32'hE);
    access(0, 3'd2, 2'd0, 0, d); chk("R6 control reset", d, 32'h0000_00CC);
    access(0, 3'd1, 2'd0, 0, d); chk("R4 status reset", d, 32'h0);
    access(0, 3'd0, 2'd0, 0, d); chk("R12 plain reset", d, 32'h0);
    // R6 forced bits
    set_ctl(8'h00);
    access(0, 3'd2, 2'd2, 0, d); chk("R6 forced bits", d, 32'h0000_00C0);
    // R12
    access(1, 3'd0, 2'd0, 32'h5A, d);
    access(1, 3'd5, 2'd0, 32'h11, d);
    access(0, 3'd0, 2'd0, 0, d); chk("R12 plain readback", d, 32'h5A);
    access(0, 3'd6, 2'd0, 0, d); chk("R12 empty offset", d, 32'hFF);
    // R2 blocked write
    set_ctl(8'h0C);
    l0 = log_n; d0 = dstb_cnt;
    access(1, 3'd4, 2'd0, 32'h77, d);
    chk("R2 blocked write no byte", log_n, l0);
    chk("R2 blocked write no strobe", dstb_cnt, d0);
    // R1 strobe select
    set_ctl(8'h04);
    l0 = log_n; a0 = astb_cnt; d0 = dstb_cnt;
    access(1, 3'd3, 2'd0, 32'h3C, d);
    chk("R1 addr strobe", astb_cnt - a0, 1);
    chk("R1 no data strobe", dstb_cnt - d0, 0);
    chk_log("R1 addr byte", l0, 1, 32'h3C, 1'b1);
    a0 = astb_cnt; d0 = dstb_cnt; l0 = log_n;
    access(1, 3'd4, 2'd0, 32'hC3, d);
    chk("R1 data strobe", dstb_cnt - d0, 1);
    chk("R1 no addr strobe", astb_cnt - a0, 0);
    chk_log("R1 data byte", l0, 1, 32'hC3, 1'b0);
    // R7 wide write and addr always one byte
    l0 = log_n;
    access(1, 3'd4, 2'd2, 32'h1122_3344, d);
    chk("R7 four bytes", log_n - l0, 4);
    chk_log("R7 byte order", l0, 4, 32'h1122_3344, 1'b0);
    l0 = log_n;
    access(1, 3'd3, 2'd2, 32'h5566_7788, d);
    chk("R7 addr one byte", log_n - l0, 1);
    // R3 blocked read
    r0 = rd_idx; d0 = dstb_cnt;
    access(0, 3'd4, 2'd1, 0, d);
    chk("R3 blocked read ones", d, 32'h0000_FFFF);
    chk("R3 blocked read no strobe", dstb_cnt - d0, 0);
    access(0, 3'd3, 2'd0, 0, d);
    chk("R3 blocked addr read", d, 32'hFF);
    chk("R3 no bytes pulled", rd_idx - r0, 0);
    // R7 wide read
    set_ctl(8'h24);
    r0 = rd_idx;
    access(0, 3'd4, 2'd1, 0, d);
    chk("R7 two byte read LE", d, exp_rd(2, 2, r0));
    r0 = rd_idx;
    access(0, 3'd4, 2'd3, 0, d);
    chk("R7 size3 read four bytes", d, exp_rd(4, 4, r0));
    // R4 timeout with dead peripheral
    set_ctl(8'h04);
    serve_limit = served;
    l0 = log_n;
    access(1, 3'd4, 2'd0, 32'h99, d);
    chk("R4 no byte on timeout", log_n - l0, 0);
    chk("R4 strobe released", {31'd0, pp_dstb_n}, 32'd1);
    access(0, 3'd1, 2'd0, 0, d); chk("R4 flag set", d, 32'h1);
    access(0, 3'd1, 2'd0, 0, d); chk("R5 flag sticky on read", d, 32'h1);
    // R5 clearing
    access(1, 3'd1, 2'd0, 32'hFE, d);
    access(0, 3'd1, 2'd0, 0, d); chk("R5 bit0 clear keeps flag", d, 32'h1);
    access(1, 3'd1, 2'd0, 32'h01, d);
    access(0, 3'd1, 2'd0, 0, d); chk("R5 bit0 set clears flag", d, 32'h0);
    // R8 wide write aborted
    serve_limit = served + 1;
    l0 = log_n;
    access(1, 3'd4, 2'd2, 32'hAABB_CCDD, d);
    chk("R8 remaining bytes skipped", log_n - l0, 1);
    chk_log("R8 first byte", l0, 1, 32'hAABB_CCDD, 1'b0);
    access(0, 3'd1, 2'd0, 0, d); chk("R8 timeout flagged", d, 32'h1);
    access(1, 3'd1, 2'd0, 32'h01, d);
    // R8 wide read aborted
    set_ctl(8'h24);
    serve_limit = served + 2;
    r0 = rd_idx;
    access(0, 3'd4, 2'd2, 0, d);
    chk("R8 partial read", d, exp_rd(4, 2, r0));
    access(0, 3'd1, 2'd0, 0, d); chk("R8 read timeout flagged", d, 32'h1);
    access(1, 3'd1, 2'd0, 32'h01, d);
    serve_limit = 32'h3FFF_FFFF;
    // random phase
    void'($urandom(32'h00C0FFEE));
    for (int it = 0; it < 150; it++) begin
      int sel = int'($urandom_range(0, 9));
      if (sel < 2) begin
        int pick = int'($urandom_range(0, 3));
        logic [7:0] v = (pick == 0) ? 8'h04 : (pick == 1) ? 8'h24 : 8'($urandom);
        set_ctl(v);
        access(0, 3'd2, 2'd0, 0, d);
        chk("R6 random control readback", d, {24'd0, ctl_sh});
      end else begin
        bit          wr  = 1'($urandom);
        logic [2:0]  off = $urandom_range(0, 1) ? 3'd3 : 3'd4;
        logic [1:0]  sz  = 2'($urandom);
        logic [31:0] wd  = $urandom;
        int          nb  = nbytes(off, sz);
        bit          ok  = wr ? ((ctl_sh & 8'h2F) == 8'h04) : ((ctl_sh & 8'h2F) == 8'h24);
        l0 = log_n; r0 = rd_idx;
        access(wr, off, sz, wd, d);
        if (wr) begin
          chk(ok ? "R7 random write count" : "R2 random blocked write", log_n - l0, ok ? nb : 0);
          if (ok && log_n <= 1024) chk_log("R11 random write bytes", l0, nb, wd, off == 3'd3);
        end else begin
          chk(ok ? "R7 random read data" : "R3 random blocked read", d,
              ok ? exp_rd(nb, nb, r0) : ones_w(nb));
        end
      end
    end
    access(0, 3'd1, 2'd0, 0, d); chk("R4 no timeout with live peripheral", d, 32'h0);
    chk("R10 port direction monitor", mon_bad_r10, 0);
    chk("R1 strobe exclusion monitor", mon_bad_r1, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule